// File: doc/BRIEF.md
# ADC Power-Down Mode Sequencer

This block is a host-side controller that moves an external parallel-output converter between three power states: active, a light power-down that keeps the converter's logic and reference powered, and a deep power-down in which only leakage remains. It drives the converter's active-low shutdown line and its active-low chip select. The level of chip select while shutdown is low picks the depth: low selects the light state and high selects the deep state.

When the host asks to wake up, the sequencer raises shutdown and holds chip select low. It then keeps the converter from seeing any conversion request until a wake-up interval has passed. Each depth has its own interval, counted in clock cycles as ceil(delay_ns × CLK_MHZ / 1000). Power requests that arrive during the countdown are queued and carried out once the countdown ends. The system sees a ready flag and a two-bit mode code.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset the block is active: `shdn_no`=1, `cs_no`=0, `ready_o`=1, `mode_o`=2'b00.
- R2: A light request (`nap_req_i`) in the active state sets `shdn_no`=0 with `cs_no`=0 and `mode_o`=2'b01 on the next clock edge. Chip select stays low for the whole light state.
- R3: A deep request (`sleep_req_i`) lowers `shdn_no` on the next edge with `cs_no` still low and sets `mode_o`=2'b10. `cs_no` then rises exactly SETUP=ceil(CS_SETUP_NS×CLK_MHZ/1000) cycles after `shdn_no` fell. `cs_no` is high only while `shdn_no` is low.
- R4: A wake request (`wake_req_i`) in the light state raises `shdn_no` on the next edge and sets `mode_o`=2'b11. `ready_o` rises exactly ceil(NAP_WAKE_NS×CLK_MHZ/1000) cycles after `shdn_no` rose.
- R5: A wake request in the deep state raises `shdn_no` and lowers `cs_no` on the same edge and sets `mode_o`=2'b11. `ready_o` rises exactly ceil(SLEEP_WAKE_NS×CLK_MHZ/1000) cycles after `shdn_no` rose.
- R6: `conv_o` equals `conv_req_i` while `ready_o` is 1, and is 0 otherwise.
- R7: Light or deep requests made during a wake countdown are stored. `ready_o` is high for exactly one cycle, and then the stored request is carried out, with deep taking priority over light.
- R8: Requests made in the same cycle are ranked deep first, then light, then wake. A light request in the deep state moves the block to the light state (`cs_no` falls while `shdn_no` stays low). A deep request in the light state goes through the R3 setup.
- R9: `ready_o` is 1 only when `mode_o`=2'b00. A wake request in the active state, or a request for the state the block is already in, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nap_req_i | input | 1 | Request light power-down |
| sleep_req_i | input | 1 | Request deep power-down |
| wake_req_i | input | 1 | Request return to active |
| conv_req_i | input | 1 | Host conversion request |
| shdn_no | output | 1 | Converter shutdown, active low |
| cs_no | output | 1 | Converter chip select, active low |
| conv_o | output | 1 | Conversion request, gated by readiness |
| ready_o | output | 1 | Converter active and usable |
| mode_o | output | 2 | 00 active, 01 light, 10 deep or entering deep, 11 waking |

## Verification
The assertions check several rules on every cycle: ready agrees with the active mode and the pin levels, chip select stays low in the light state, chip select is high only during shutdown, and conversions pass only while ready. They also use counters to check that chip select rises no earlier than the setup count after shutdown falls, and that ready rises exactly the depth-specific wake count after shutdown rises. Only the bench scenarios can show the rest: the queued request being carried out after one ready cycle, the ranking between simultaneous requests, the direct move from deep to light, and requests that are ignored. A cycle-level model in the bench checks these against the pins throughout a random run.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE, ST_NAP, ST_SETUP, ST_SLEEP, ST_WAKE
  } pdm_state_e;

  localparam logic [1:0] MODE_ACTIVE = 2'b00;
  localparam logic [1:0] MODE_NAP    = 2'b01;
  localparam logic [1:0] MODE_SLEEP  = 2'b10;
  localparam logic [1:0] MODE_WAKE   = 2'b11;

  // ceil(ns * mhz / 1000), never below one cycle
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
    longint unsigned prod;
    prod = (64'(ns) * 64'(mhz) + 64'd999) / 64'd1000;
    if (prod == 64'd0) prod = 64'd1;
    return 32'(prod);
  endfunction
endpackage

// File: rtl/pdm_wait_timer.sv
module pdm_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  // last counted cycle: the owner moves on at this edge
  assign expire_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pdm_req_queue.sv
module pdm_req_queue (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic drain_i,
  input  logic nap_i,
  input  logic sleep_i,
  output logic pend_nap_o,
  output logic pend_sleep_o
);
  logic nap_q, sleep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nap_q   <= 1'b0;
      sleep_q <= 1'b0;
    end else if (drain_i) begin
      nap_q   <= 1'b0;
      sleep_q <= 1'b0;
    end else if (capture_i) begin
      nap_q   <= nap_q | nap_i;
      sleep_q <= sleep_q | sleep_i;
    end
  end

  assign pend_nap_o   = nap_q;
  assign pend_sleep_o = sleep_q;
endmodule

// File: rtl/pdm_mode_fsm.sv
module pdm_mode_fsm import pdm_pkg::*; #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned NAP_CYC = 1,
  parameter int unsigned SLP_CYC = 1,
  parameter int unsigned SET_CYC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nap_i,
  input  logic             sleep_i,
  input  logic             wake_i,
  input  logic             expire_i,
  output pdm_state_e       state_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);
  pdm_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_ACTIVE: begin
        if (sleep_i) begin
          state_d = ST_SETUP; load_o = 1'b1; load_val_o = CNT_W'(SET_CYC);
        end else if (nap_i) begin
          state_d = ST_NAP;
        end
      end
      ST_NAP: begin
        if (sleep_i) begin
          state_d = ST_SETUP; load_o = 1'b1; load_val_o = CNT_W'(SET_CYC);
        end else if (wake_i) begin
          state_d = ST_WAKE; load_o = 1'b1; load_val_o = CNT_W'(NAP_CYC);
        end
      end
      ST_SETUP: if (expire_i) state_d = ST_SLEEP;
      ST_SLEEP: begin
        if (nap_i) begin
          state_d = ST_NAP;
        end else if (wake_i) begin
          state_d = ST_WAKE; load_o = 1'b1; load_val_o = CNT_W'(SLP_CYC);
        end
      end
      ST_WAKE:  if (expire_i) state_d = ST_ACTIVE;
      default:  state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ACTIVE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq import pdm_pkg::*; #(
  parameter int unsigned CLK_MHZ       = 125,
  parameter int unsigned NAP_WAKE_NS   = 400,
  parameter int unsigned SLEEP_WAKE_NS = 80_000_000,
  parameter int unsigned CS_SETUP_NS   = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       nap_req_i,
  input  logic       sleep_req_i,
  input  logic       wake_req_i,
  input  logic       conv_req_i,
  output logic       shdn_no,
  output logic       cs_no,
  output logic       conv_o,
  output logic       ready_o,
  output logic [1:0] mode_o
);
  localparam int unsigned NAP_CYC = ns_to_cycles(NAP_WAKE_NS, CLK_MHZ);
  localparam int unsigned SLP_CYC = ns_to_cycles(SLEEP_WAKE_NS, CLK_MHZ);
  localparam int unsigned SET_CYC = ns_to_cycles(CS_SETUP_NS, CLK_MHZ);
  localparam int unsigned MAX_A   = (NAP_CYC > SLP_CYC) ? NAP_CYC : SLP_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > SET_CYC) ? MAX_A : SET_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  pdm_state_e       state;
  logic             load, expire, pend_nap, pend_sleep;
  logic [CNT_W-1:0] load_val;

  pdm_req_queue u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .capture_i   (state == ST_WAKE),
    .drain_i     (state == ST_ACTIVE),
    .nap_i       (nap_req_i),
    .sleep_i     (sleep_req_i),
    .pend_nap_o  (pend_nap),
    .pend_sleep_o(pend_sleep)
  );

  pdm_mode_fsm #(
    .CNT_W  (CNT_W),
    .NAP_CYC(NAP_CYC),
    .SLP_CYC(SLP_CYC),
    .SET_CYC(SET_CYC)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nap_i     (nap_req_i | pend_nap),
    .sleep_i   (sleep_req_i | pend_sleep),
    .wake_i    (wake_req_i),
    .expire_i  (expire),
    .state_o   (state),
    .load_o    (load),
    .load_val_o(load_val)
  );

  pdm_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .expire_o  (expire)
  );

  always_comb begin
    unique case (state)
      ST_NAP:             mode_o = MODE_NAP;
      ST_SETUP, ST_SLEEP: mode_o = MODE_SLEEP;
      ST_WAKE:            mode_o = MODE_WAKE;
      default:            mode_o = MODE_ACTIVE;
    endcase
  end

  assign shdn_no = (state == ST_ACTIVE) || (state == ST_WAKE);
  assign cs_no   = (state == ST_SLEEP);
  assign ready_o = (state == ST_ACTIVE);
  assign conv_o  = conv_req_i & ready_o;
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk import pdm_pkg::*; #(
  parameter int unsigned CLK_MHZ       = 125,
  parameter int unsigned NAP_WAKE_NS   = 400,
  parameter int unsigned SLEEP_WAKE_NS = 80_000_000,
  parameter int unsigned CS_SETUP_NS   = 10
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       conv_req_i,
  input logic       shdn_no,
  input logic       cs_no,
  input logic       conv_o,
  input logic       ready_o,
  input logic [1:0] mode_o
);
  localparam int unsigned NAP_CYC = ns_to_cycles(NAP_WAKE_NS, CLK_MHZ);
  localparam int unsigned SLP_CYC = ns_to_cycles(SLEEP_WAKE_NS, CLK_MHZ);
  localparam int unsigned SET_CYC = ns_to_cycles(CS_SETUP_NS, CLK_MHZ);

  int unsigned lo_cnt, hi_cnt;
  logic        from_sleep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt     <= 0;
      hi_cnt     <= 0;
      from_sleep <= 1'b0;
    end else begin
      if (shdn_no) lo_cnt <= 0;
      else if (lo_cnt != 32'hFFFF_FFFF) lo_cnt <= lo_cnt + 1;
      if (!shdn_no) begin
        hi_cnt     <= 0;
        from_sleep <= (mode_o == MODE_SLEEP);
      end else if (hi_cnt != 32'hFFFF_FFFF) hi_cnt <= hi_cnt + 1;
    end
  end

  AST_READY_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (shdn_no && !cs_no && mode_o == MODE_ACTIVE)); // R9
  AST_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != MODE_ACTIVE) |-> !ready_o); // R9
  AST_CONV_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> (ready_o && conv_req_i)); // R6
  AST_CONV_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && conv_req_i) |-> conv_o); // R6
  AST_NAP_CS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_NAP) |-> (!shdn_no && !cs_no)); // R2
  AST_CS_IN_SHDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !shdn_no); // R3
  AST_CS_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (lo_cnt >= SET_CYC)); // R3
  AST_WAKE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (hi_cnt == (from_sleep ? SLP_CYC : NAP_CYC))); // R4 R5
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(
  .CLK_MHZ      (CLK_MHZ),
  .NAP_WAKE_NS  (NAP_WAKE_NS),
  .SLEEP_WAKE_NS(SLEEP_WAKE_NS),
  .CS_SETUP_NS  (CS_SETUP_NS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .conv_req_i(conv_req_i),
  .shdn_no   (shdn_no),
  .cs_no     (cs_no),
  .conv_o    (conv_o),
  .ready_o   (ready_o),
  .mode_o    (mode_o)
);

// File: tb/adc_pwr_seq_tb.sv
module adc_pwr_seq_tb;
  localparam int CLK_MHZ = 125;
  localparam int NAP_NS  = 400;
  localparam int SLP_NS  = 4000;
  localparam int SET_NS  = 10;

  function automatic int exp_cyc(input int ns);
    return (ns * CLK_MHZ + 999) / 1000;
  endfunction

  localparam int NAP_C = (NAP_NS * CLK_MHZ + 999) / 1000;
  localparam int SLP_C = (SLP_NS * CLK_MHZ + 999) / 1000;
  localparam int SET_C = (SET_NS * CLK_MHZ + 999) / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic nap = 1'b0, slp = 1'b0, wake = 1'b0, conv = 1'b0;
  logic shdn_n, cs_n, conv_q, ready;
  logic [1:0] mode;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic chk_en = 1'b0;

  always #4 clk = ~clk;

  adc_pwr_seq #(
    .CLK_MHZ(CLK_MHZ), .NAP_WAKE_NS(NAP_NS),
    .SLEEP_WAKE_NS(SLP_NS), .CS_SETUP_NS(SET_NS)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .nap_req_i(nap), .sleep_req_i(slp),
    .wake_req_i(wake), .conv_req_i(conv), .shdn_no(shdn_n), .cs_no(cs_n),
    .conv_o(conv_q), .ready_o(ready), .mode_o(mode)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // cycle-level reference model: 0 active,1 nap,2 setup,3 sleep,4 waking
  int m_st = 0, m_cnt = 0;
  logic m_pn = 1'b0, m_ps = 1'b0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_pn = 1'b0; m_ps = 1'b0;
    end else begin
      cyc++;
      case (m_st)
        0: begin
          if (slp | m_ps) begin m_st = 2; m_cnt = SET_C; end
          else if (nap | m_pn) m_st = 1;
          m_pn = 1'b0; m_ps = 1'b0;
        end
        1: if (slp) begin m_st = 2; m_cnt = SET_C; end
           else if (wake) begin m_st = 4; m_cnt = NAP_C; end
        2: if (m_cnt == 1) m_st = 3; else m_cnt--;
        3: if (nap) m_st = 1;
           else if (wake) begin m_st = 4; m_cnt = SLP_C; end
        default: begin
          m_pn = m_pn | nap; m_ps = m_ps | slp;
          if (m_cnt == 1) m_st = 0; else m_cnt--;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      check("R9 ready", int'(ready), int'(m_st == 0));
      check("R2 mode", int'(mode), (m_st == 0) ? 0 : (m_st == 1) ? 1 : (m_st == 4) ? 3 : 2);
      check("R3 shdn_no", int'(shdn_n), int'(m_st == 0 || m_st == 4));
      check("R3 cs_no", int'(cs_n), int'(m_st == 3));
      check("R6 conv", int'(conv_q), int'(conv && m_st == 0));
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      nap = 1'b0; slp = 1'b0; wake = 1'b0;
    end
  endtask

  task automatic pulse(input logic n_r, input logic s_r, input logic w_r);
    @(negedge clk); #1;
    nap = n_r; slp = s_r; wake = w_r;
    @(negedge clk); #1;
    nap = 1'b0; slp = 1'b0; wake = 1'b0;
  endtask

  task automatic wait_ready(output int k);
    k = 0;
    while (!ready && k < 10000) begin @(negedge clk); k++; end
  endtask

  int k;
  initial begin
    void'($urandom(32'd20240607));
    #21 rst_n = 1'b1;
    @(negedge clk);
    check("R1 shdn_no", int'(shdn_n), 1);
    check("R1 cs_no", int'(cs_n), 0);
    check("R1 ready", int'(ready), 1);
    check("R1 mode", int'(mode), 0);
    chk_en = 1'b1;

    // R9: wake while active is ignored
    pulse(1'b0, 1'b0, 1'b1);
    check("R9 wake ignored mode", int'(mode), 0);

    // R2 / R6 light entry
    conv = 1'b1;
    pulse(1'b1, 1'b0, 1'b0);
    check("R2 nap shdn_no", int'(shdn_n), 0);
    check("R2 nap mode", int'(mode), 1);
    check("R6 conv blocked", int'(conv_q), 0);
    conv = 1'b0;

    // R4 wake from light
    @(negedge clk); #1 wake = 1'b1;
    @(negedge clk); #1 wake = 1'b0;
    check("R4 waking mode", int'(mode), 3);
    wait_ready(k);
    check("R4 nap wake cycles", k, exp_cyc(NAP_NS));
    #1 conv = 1'b1;
    @(negedge clk);
    check("R6 conv passes", int'(conv_q), 1);
    #1 conv = 1'b0;

    // R3 deep entry and setup
    @(negedge clk); #1 slp = 1'b1;
    @(negedge clk); #1 slp = 1'b0;
    check("R3 shdn first", int'(shdn_n), 0);
    check("R3 cs still low", int'(cs_n), 0);
    k = 0;
    while (!cs_n && k < 100) begin @(negedge clk); k++; end
    check("R3 setup cycles", k, exp_cyc(SET_NS));

    // R5 wake from deep
    @(negedge clk); #1 wake = 1'b1;
    @(negedge clk); #1 wake = 1'b0;
    check("R5 cs falls with shdn", int'(cs_n), 0);
    check("R5 shdn rises", int'(shdn_n), 1);
    wait_ready(k);
    check("R5 sleep wake cycles", k, exp_cyc(SLP_NS));

    // R7 queued request during countdown
    pulse(1'b1, 1'b0, 1'b0);
    pulse(1'b0, 1'b0, 1'b1);
    tick(5);
    @(negedge clk); #1 nap = 1'b1; slp = 1'b1;
    tick(1);
    wait_ready(k);
    check("R7 ready reached", int'(ready), 1);
    @(negedge clk);
    check("R7 queued deep wins", int'(mode), 2);
    check("R7 ready one cycle", int'(ready), 0);
    tick(SET_C + 2);

    // R8 in deep: light beats wake
    pulse(1'b1, 1'b0, 1'b1);
    check("R8 deep to light mode", int'(mode), 1);
    check("R8 deep to light cs", int'(cs_n), 0);
    // R8 in light: deep beats wake
    pulse(1'b0, 1'b1, 1'b1);
    check("R8 light to deep mode", int'(mode), 2);
    tick(SET_C + 2);
    pulse(1'b0, 1'b1, 1'b0);
    check("R9 repeat deep ignored", int'(cs_n), 1);
    pulse(1'b0, 1'b0, 1'b1);
    wait_ready(k);
    // R8 active: deep beats light
    pulse(1'b1, 1'b1, 1'b0);
    check("R8 active deep wins", int'(mode), 2);

    // random phase
    for (int i = 0; i < 160; i++) begin
      int op;
      op = int'($urandom % 7);
      @(negedge clk); #1;
      conv = 1'($urandom);
      nap  = (op == 0 || op == 3 || op == 5);
      slp  = (op == 1 || op == 3);
      wake = (op == 2 || op == 5 || op == 6);
      for (int g = 0; g <= int'($urandom % 40); g++) begin
        @(negedge clk); #1;
        nap = 1'b0; slp = 1'b0; wake = 1'b0; conv = 1'($urandom);
      end
    end
    pulse(1'b0, 1'b0, 1'b1);
    tick(SLP_C + 4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule